// File: doc/BRIEF.md
# Memory Access Ordering Window

This block sits between an instruction pipeline and the memory side. It holds up to a fixed number of pending memory operations in program order. Each operation carries three attributes: an ordering kind (fence, acquire, release or unordered), a page attribute (sequential or non-sequential) and a flag that marks an interprocessor interrupt message.

Every cycle the block picks one pending operation that may go to the memory side and issues it. Eligibility is decided pairwise against every older operation that has not been acknowledged. Some pairs need visibility order: the younger operation must wait until the older one has been acknowledged. Other pairs need only peripheral arrival order: the younger operation must wait until the older one has been issued. The rest need no order at all. When several operations are eligible, the oldest one is issued.

Operations enter through an allocate handshake, which reports the slot each one receives. They leave the window from the head, in order, once they have been acknowledged.

Top module: `mem_order_window`

## Requirements
- R1: After reset, alloc_ready_o is 1, issue_valid_o is 0 and alloc_idx_o is 0.
- R2: An operation is accepted on a cycle with alloc_valid_i and alloc_ready_o both high. Slots are handed out consecutively modulo the depth, and alloc_idx_o shows the slot that the next accepted operation will take. alloc_ready_o is 0 while all 8 slots are occupied.
- R3: Slots are freed strictly from the oldest end, one per cycle, and only once acknowledged. An acknowledged slot behind an unacknowledged older slot stays occupied.
- R4: At most one operation issues per cycle, and each operation issues exactly once. Among eligible operations the oldest issues first, so operations that are freed together issue on consecutive cycles in program order.
- R5: Kind code 0 is fence. If either operation of a pair is a fence, the younger one does not issue until the older one has been acknowledged.
- R6: Kind code 1 is acquire. No operation younger than an unacknowledged acquire issues.
- R7: Kind code 2 is release. A release does not issue until every older operation has been acknowledged.
- R8: Kind code 3 is unordered. When the older operation is a release or unordered and the younger is an acquire or unordered, and the two are not both on sequential pages (alloc_seq_i = 1), the younger may issue while the older is still waiting or unacknowledged.
- R9: When both operations are on sequential pages, neither is a fence, and visibility order is not otherwise required, the younger issues only after the older has issued, without waiting for its acknowledgment.
- R10: A pair in which both operations carry the interrupt-message flag (alloc_ipi_i = 1) imposes no ordering between them.
- R11: An acknowledgment that names a slot whose operation has not been issued is ignored. That operation still issues later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | New operation offered |
| alloc_ready_o | output | 1 | Window can accept an operation |
| alloc_kind_i | input | 2 | Kind: 0 fence, 1 acquire, 2 release, 3 unordered |
| alloc_seq_i | input | 1 | Operation targets a sequential page |
| alloc_ipi_i | input | 1 | Operation is an interprocessor interrupt message |
| alloc_idx_o | output | 3 | Slot given to the next accepted operation |
| issue_valid_o | output | 1 | An operation is issued this cycle |
| issue_idx_o | output | 3 | Slot of the issued operation |
| ack_valid_i | input | 1 | Completion acknowledgment |
| ack_idx_i | input | 3 | Slot being acknowledged |

## Verification
Two events can share a cycle. In one, an acknowledgment releases an older operation while a younger, independent operation is issued. In the other, allocation at the tail meets retirement at the head.

The bench provokes the first case by holding back one release behind an unordered operation. A sequential or message-flagged operation queued behind that release then either slips past it or waits for it, and each outcome is compared with the pairwise rule. It provokes the second case by filling the window and acknowledging slots out of order, then checking that readiness returns only once the head has drained.

// File: rtl/mow_pkg.sv
package mow_pkg;
  typedef enum logic [1:0] {
    OP_FENCE = 2'd0,
    OP_ACQ   = 2'd1,
    OP_REL   = 2'd2,
    OP_UNORD = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ISSUED = 2'd2,
    ST_DONE   = 2'd3
  } slot_st_e;

  typedef struct packed {
    op_kind_e kind;
    logic     seq;
    logic     ipi;
  } op_attr_t;
endpackage

// File: rtl/mow_pair_rule.sv
module mow_pair_rule
  import mow_pkg::*;
(
  input  op_attr_t older_i,
  input  op_attr_t younger_i,
  output logic     need_vis_o,
  output logic     need_per_o
);
  logic exempt;
  logic any_fence;

  assign exempt    = older_i.ipi & younger_i.ipi;
  assign any_fence = (older_i.kind == OP_FENCE) | (younger_i.kind == OP_FENCE);

  // visibility: fence on either side, older acquire, younger release
  assign need_vis_o = ~exempt & (any_fence | (older_i.kind == OP_ACQ) |
                                 (younger_i.kind == OP_REL));
  // peripheral arrival: both sequential, no fence involved
  assign need_per_o = ~exempt & ~any_fence & older_i.seq & younger_i.seq;
endmodule

// File: rtl/mow_ptr_ctrl.sv
module mow_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) tail_o <= wrap_inc(tail_o);
      if (pop_i)  head_o <= wrap_inc(head_o);
      if (push_i && !pop_i)      count_o <= count_o + 1'b1;
      else if (pop_i && !push_i) count_o <= count_o - 1'b1;
    end
  end

  assign full_o = (count_o == CNT_W'(DEPTH));
endmodule

// File: rtl/mow_pick_oldest.sv
module mow_pick_oldest #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [IDX_W-1:0] head_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from youngest to oldest so the oldest request wins
  always_comb begin
    int s;
    valid_o = 1'b0;
    idx_o   = head_i;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      s = (int'(head_i) + k) % DEPTH;
      if (req_i[s]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/mem_order_window.sv
module mem_order_window
  import mow_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  output logic             alloc_ready_o,
  input  logic [1:0]       alloc_kind_i,
  input  logic             alloc_seq_i,
  input  logic             alloc_ipi_i,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic             issue_valid_o,
  output logic [IDX_W-1:0] issue_idx_o,
  input  logic             ack_valid_i,
  input  logic [IDX_W-1:0] ack_idx_i
);
  slot_st_e [DEPTH-1:0] st_q;
  op_attr_t [DEPTH-1:0] attr_q;

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             alloc_fire;
  logic             retire;

  logic [DEPTH*DEPTH-1:0] need_vis, need_per;
  logic [IDX_W-1:0]       age [DEPTH];
  logic [DEPTH-1:0]       blocked, eligible;

  assign alloc_ready_o = ~full;
  assign alloc_fire    = alloc_valid_i & ~full;
  assign alloc_idx_o   = tail;
  assign retire        = (st_q[head] == ST_DONE);

  mow_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (retire),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count),
    .full_o  (full)
  );

  // pairwise rule: index o*DEPTH+y, o older candidate, y younger candidate
  for (genvar o = 0; o < DEPTH; o++) begin : g_old
    for (genvar y = 0; y < DEPTH; y++) begin : g_young
      if (o == y) begin : g_self
        assign need_vis[o*DEPTH+y] = 1'b0;
        assign need_per[o*DEPTH+y] = 1'b0;
      end else begin : g_rule
        mow_pair_rule u_rule (
          .older_i    (attr_q[o]),
          .younger_i  (attr_q[y]),
          .need_vis_o (need_vis[o*DEPTH+y]),
          .need_per_o (need_per[o*DEPTH+y])
        );
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i] = IDX_W'((i + DEPTH - int'(head)) % DEPTH);
    end
  end

  always_comb begin
    for (int y = 0; y < DEPTH; y++) begin
      blocked[y] = 1'b0;
      for (int o = 0; o < DEPTH; o++) begin
        if (o != y && age[o] < age[y]) begin
          if (need_vis[o*DEPTH+y] && (st_q[o] == ST_WAIT || st_q[o] == ST_ISSUED))
            blocked[y] = 1'b1;
          if (need_per[o*DEPTH+y] && st_q[o] == ST_WAIT)
            blocked[y] = 1'b1;
        end
      end
      eligible[y] = (st_q[y] == ST_WAIT) & ~blocked[y];
    end
  end

  mow_pick_oldest #(.DEPTH(DEPTH)) u_pick (
    .req_i   (eligible),
    .head_i  (head),
    .valid_o (issue_valid_o),
    .idx_o   (issue_idx_o)
  );

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[s]   <= ST_FREE;
        attr_q[s] <= '0;
      end else begin
        unique case (st_q[s])
          ST_FREE: if (alloc_fire && tail == IDX_W'(s)) begin
            st_q[s]   <= ST_WAIT;
            attr_q[s] <= '{kind: op_kind_e'(alloc_kind_i), seq: alloc_seq_i,
                           ipi: alloc_ipi_i};
          end
          ST_WAIT: if (issue_valid_o && issue_idx_o == IDX_W'(s))
            st_q[s] <= ST_ISSUED;
          ST_ISSUED: if (ack_valid_i && ack_idx_i == IDX_W'(s))
            st_q[s] <= ST_DONE;
          ST_DONE: if (retire && head == IDX_W'(s))
            st_q[s] <= ST_FREE;
          default: st_q[s] <= ST_FREE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mow_window_chk.sv
module mow_window_chk
  import mow_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               alloc_ready_o,
  input logic               issue_valid_o,
  input logic [IDX_W-1:0]   issue_idx_o,
  input logic               ack_valid_i,
  input logic [IDX_W-1:0]   ack_idx_i,
  input logic [2*DEPTH-1:0] st_i,
  input logic [IDX_W-1:0]   head_i,
  input logic [CNT_W-1:0]   count_i
);
  function automatic logic [1:0] st_at(input logic [2*DEPTH-1:0] v, input logic [IDX_W-1:0] k);
    return v[2*k +: 2];
  endfunction

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_W'(DEPTH)) |-> !alloc_ready_o);

  p_oldest_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0 && st_at(st_i, head_i) == ST_WAIT) |->
      (issue_valid_o && issue_idx_o == head_i));

  p_issue_waiting_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> st_at(st_i, issue_idx_o) == ST_WAIT);

  p_issue_marks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> st_at(st_i, $past(issue_idx_o)) == ST_ISSUED);

  p_retire_head_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != '0 && st_at(st_i, head_i) == ST_DONE) |=> head_i == nxt($past(head_i)));

  p_early_ack_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && st_at(st_i, ack_idx_i) == ST_WAIT &&
     !(issue_valid_o && issue_idx_o == ack_idx_i)) |=>
      st_at(st_i, $past(ack_idx_i)) == ST_WAIT);
endmodule

bind mem_order_window mow_window_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_ready_o (alloc_ready_o),
  .issue_valid_o (issue_valid_o),
  .issue_idx_o   (issue_idx_o),
  .ack_valid_i   (ack_valid_i),
  .ack_idx_i     (ack_idx_i),
  .st_i          (st_q),
  .head_i        (head),
  .count_i       (count)
);

// File: tb/mem_order_window_tb.sv
module mem_order_window_tb;
  localparam int N_OPS = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alloc_valid_i = 1'b0;
  logic       alloc_ready_o;
  logic [1:0] alloc_kind_i = '0;
  logic       alloc_seq_i = 1'b0;
  logic       alloc_ipi_i = 1'b0;
  logic [2:0] alloc_idx_o;
  logic       issue_valid_o;
  logic [2:0] issue_idx_o;
  logic       ack_valid_i = 1'b0;
  logic [2:0] ack_idx_i = '0;

  mem_order_window u_dut (.*);

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int n_ops = 0;
  int last_op;
  int op_kind [N_OPS];
  bit op_seq [N_OPS];
  bit op_ipi [N_OPS];
  int op_slot [N_OPS];
  int op_issue_t [N_OPS];
  int op_ack_t [N_OPS];
  int slot2op [8];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  always @(posedge clk_i) begin
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 50000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue monitor: issue seen at negedge takes effect at the next edge
  always @(negedge clk_i) begin
    if (rst_ni && issue_valid_o) begin
      int op;
      op = slot2op[issue_idx_o];
      chk(op_issue_t[op] < 0, "R4 single issue", op_issue_t[op], -1);
      op_issue_t[op] = cyc + 1;
    end
  end

  // independent rule model
  function automatic bit want_vis(input int a, input int b);
    if (op_ipi[a] && op_ipi[b]) return 1'b0;
    return op_kind[a] == 0 || op_kind[b] == 0 || op_kind[a] == 1 || op_kind[b] == 2;
  endfunction

  function automatic bit want_per(input int a, input int b);
    if (op_ipi[a] && op_ipi[b]) return 1'b0;
    return op_seq[a] && op_seq[b] && op_kind[a] != 0 && op_kind[b] != 0;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic alloc_op(input int kind, input bit seq, input bit ipi);
    @(negedge clk_i);
    while (!alloc_ready_o) @(negedge clk_i);
    alloc_valid_i = 1'b1;
    alloc_kind_i  = 2'(kind);
    alloc_seq_i   = seq;
    alloc_ipi_i   = ipi;
    op_kind[n_ops]    = kind;
    op_seq[n_ops]     = seq;
    op_ipi[n_ops]     = ipi;
    op_slot[n_ops]    = int'(alloc_idx_o);
    op_issue_t[n_ops] = -1;
    op_ack_t[n_ops]   = -1;
    slot2op[alloc_idx_o] = n_ops;
    last_op = n_ops;
    n_ops++;
    @(negedge clk_i);
    alloc_valid_i = 1'b0;
  endtask

  task automatic ack_raw(input int slot);
    @(negedge clk_i);
    ack_valid_i = 1'b1;
    ack_idx_i   = 3'(slot);
    @(negedge clk_i);
    ack_valid_i = 1'b0;
  endtask

  task automatic ack_op(input int op);
    @(negedge clk_i);
    while (op_issue_t[op] < 0 || cyc < op_issue_t[op]) @(negedge clk_i);
    ack_valid_i = 1'b1;
    ack_idx_i   = 3'(op_slot[op]);
    op_ack_t[op] = cyc + 1;
    @(negedge clk_i);
    ack_valid_i = 1'b0;
  endtask

  task automatic drain(input int first);
    for (int k = first; k < n_ops; k++) if (op_ack_t[k] < 0) ack_op(k);
    repeat (10) @(negedge clk_i);
  endtask

  task automatic check_pairs(input int first);
    for (int a = first; a < n_ops; a++) begin
      for (int b = a + 1; b < n_ops; b++) begin
        if (want_vis(a, b)) begin
          string r;
          r = (op_kind[a] == 0 || op_kind[b] == 0) ? "R5 pair" :
              (op_kind[a] == 1) ? "R6 pair" : "R7 pair";
          chk(op_issue_t[b] > op_ack_t[a], r, op_issue_t[b], op_ack_t[a] + 1);
        end else if (want_per(a, b)) begin
          chk(op_issue_t[b] > op_issue_t[a], "R9 pair", op_issue_t[b], op_issue_t[a] + 1);
        end
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(alloc_ready_o == 1'b1, "R1 ready", alloc_ready_o, 1);
    chk(issue_valid_o == 1'b0, "R1 issue", issue_valid_o, 0);
    chk(alloc_idx_o == 3'd0, "R1 index", alloc_idx_o, 0);
  endtask

  task automatic t_fence();
    int f0, x, fe, b;
    f0 = n_ops;
    alloc_op(3, 0, 0); x = last_op;
    alloc_op(0, 0, 0); fe = last_op;
    alloc_op(3, 0, 0); b = last_op;
    repeat (5) @(negedge clk_i);
    chk(op_issue_t[fe] < 0, "R5 fence waits", op_issue_t[fe], -1);
    chk(op_issue_t[b] < 0, "R5 after fence", op_issue_t[b], -1);
    ack_op(x);
    repeat (3) @(negedge clk_i);
    chk(op_issue_t[fe] >= 0, "R5 fence released", op_issue_t[fe], 1);
    chk(op_issue_t[b] < 0, "R5 still behind fence", op_issue_t[b], -1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_acquire();
    int f0, a, b;
    f0 = n_ops;
    alloc_op(1, 0, 0); a = last_op;
    alloc_op(3, 0, 0); b = last_op;
    repeat (5) @(negedge clk_i);
    chk(op_issue_t[a] >= 0, "R6 acquire issued", op_issue_t[a], 1);
    chk(op_issue_t[b] < 0, "R6 younger held", op_issue_t[b], -1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_release();
    int f0, a, b, c;
    f0 = n_ops;
    alloc_op(3, 0, 0); a = last_op;
    alloc_op(3, 0, 0); b = last_op;
    alloc_op(2, 0, 0); c = last_op;
    repeat (4) @(negedge clk_i);
    chk(op_issue_t[b] >= 0, "R8 unordered pair", op_issue_t[b], 1);
    chk(op_issue_t[c] < 0, "R7 release held", op_issue_t[c], -1);
    ack_op(a);
    repeat (3) @(negedge clk_i);
    chk(op_issue_t[c] < 0, "R7 release held by second", op_issue_t[c], -1);
    ack_op(b);
    repeat (3) @(negedge clk_i);
    chk(op_issue_t[c] >= 0, "R7 release issued", op_issue_t[c], 1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_nonseq_bypass();
    int f0, a, b;
    f0 = n_ops;
    alloc_op(3, 0, 0);
    alloc_op(2, 0, 0); a = last_op;
    alloc_op(3, 0, 0); b = last_op;
    repeat (5) @(negedge clk_i);
    chk(op_issue_t[a] < 0, "R7 release waits", op_issue_t[a], -1);
    chk(op_issue_t[b] >= 0, "R8 passes waiting release", op_issue_t[b], 1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_seq_order();
    int f0, x, a, b;
    f0 = n_ops;
    alloc_op(3, 0, 0); x = last_op;
    alloc_op(2, 1, 0); a = last_op;
    alloc_op(3, 1, 0); b = last_op;
    repeat (5) @(negedge clk_i);
    chk(op_issue_t[b] < 0, "R9 sequential held", op_issue_t[b], -1);
    ack_op(x);
    repeat (4) @(negedge clk_i);
    chk(op_issue_t[a] >= 0, "R9 older issued", op_issue_t[a], 1);
    chk(op_issue_t[b] > op_issue_t[a], "R9 arrival order", op_issue_t[b], op_issue_t[a] + 1);
    chk(op_ack_t[a] < 0, "R9 no visibility wait", op_ack_t[a], -1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_ipi();
    int f0, a, b;
    f0 = n_ops;
    alloc_op(3, 0, 0);
    alloc_op(2, 1, 1); a = last_op;
    alloc_op(3, 1, 1); b = last_op;
    repeat (5) @(negedge clk_i);
    chk(op_issue_t[a] < 0, "R10 flagged release waits", op_issue_t[a], -1);
    chk(op_issue_t[b] >= 0, "R10 messages unordered", op_issue_t[b], 1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_full();
    int f0, start;
    f0 = n_ops;
    @(negedge clk_i);
    start = int'(alloc_idx_o);
    for (int k = 0; k < 8; k++) begin
      alloc_op(3, 0, 0);
      chk(op_slot[last_op] == (start + k) % 8, "R2 slot order", op_slot[last_op], (start + k) % 8);
    end
    @(negedge clk_i);
    chk(alloc_ready_o == 1'b0, "R2 full", alloc_ready_o, 0);
    ack_op(f0 + 1);
    repeat (3) @(negedge clk_i);
    chk(alloc_ready_o == 1'b0, "R3 head blocks retire", alloc_ready_o, 0);
    ack_op(f0);
    repeat (3) @(negedge clk_i);
    chk(alloc_ready_o == 1'b1, "R3 retire frees", alloc_ready_o, 1);
    chk(alloc_idx_o == 3'(start), "R2 tail wrapped", alloc_idx_o, start);
    drain(f0);
  endtask

  task automatic t_bad_ack();
    int f0, x, a;
    f0 = n_ops;
    alloc_op(3, 0, 0); x = last_op;
    alloc_op(2, 0, 0); a = last_op;
    repeat (3) @(negedge clk_i);
    ack_raw(op_slot[a]);
    repeat (3) @(negedge clk_i);
    chk(op_issue_t[a] < 0, "R11 still waiting", op_issue_t[a], -1);
    ack_op(x);
    repeat (4) @(negedge clk_i);
    chk(op_issue_t[a] >= 0, "R11 issues after early ack", op_issue_t[a], 1);
    drain(f0);
    check_pairs(f0);
  endtask

  task automatic t_oldest();
    int f0, x, a, b, c;
    f0 = n_ops;
    alloc_op(1, 0, 0); x = last_op;
    alloc_op(3, 0, 0); a = last_op;
    alloc_op(3, 0, 0); b = last_op;
    alloc_op(3, 0, 0); c = last_op;
    repeat (3) @(negedge clk_i);
    ack_op(x);
    repeat (6) @(negedge clk_i);
    chk(op_issue_t[b] == op_issue_t[a] + 1, "R4 consecutive", op_issue_t[b], op_issue_t[a] + 1);
    chk(op_issue_t[c] == op_issue_t[b] + 1, "R4 program order", op_issue_t[c], op_issue_t[b] + 1);
    drain(f0);
    check_pairs(f0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) slot2op[k] = 0;
    do_reset();
    t_reset();
    t_fence();
    t_acquire();
    t_release();
    t_nonseq_bypass();
    t_seq_order();
    t_ipi();
    t_full();
    t_bad_ack();
    t_oldest();
    summary();
    $finish;
  end
endmodule